// File: doc/BRIEF.md
# Enclave Region Access Checker

This block sits in front of one memory bank and screens every access to it. Host software programs a protected address window as a base and a mask, then locks it. While the window is locked, host reads and writes that land inside it never reach the bank. A blocked read gets a response marked as null, with an all-zero data field. A blocked write is discarded and recorded as a violation. An internal enclave engine has its own request port. Its accesses always reach the bank, and it alone can release the lock.

Two named states govern the window. In `ST_OPEN` every host access is allowed and the base and mask registers accept writes. Transition `T_LOCK`, taken on a lock command, moves to `ST_LOCKED`. In `ST_LOCKED` the window is enforced and its bounds are frozen. Transition `T_UNLOCK`, taken on an enclave unlock pulse, returns to `ST_OPEN` and clears both bounds. The host response arrives exactly one cycle after acceptance whether the access was allowed or blocked, so the timing of a response does not reveal a hit. The bank is assumed to return read data one cycle after a read is issued.

Top module: `enclave_guard`

## Requirements
- R1: While locked, a host address hits the window when (addr AND mask) equals (base AND mask). A mask of zero therefore covers every address.
- R2: A host read that hits the locked window does not access the bank. It receives a response with `h_rsp_null` = 1 and `h_rsp_rdata` all zero.
- R3: A host write that hits the locked window does not access the bank, so the stored word is unchanged. Its response carries `h_rsp_null` = 1.
- R4: Each blocked host write sets `viol_flag` and adds one to `viol_count`. The flag stays set until reset, including across an unlock. The counter saturates at its maximum. Blocked reads change neither.
- R5: Every accepted host access, allowed or blocked, gets exactly one `h_rsp_valid` pulse in the following cycle. No response appears without an accepted request.
- R6: Enclave accesses reach the bank whatever the lock state. A read returns the stored word on `e_rsp_rdata` with `e_rsp_valid` one cycle later.
- R7: When an enclave request is present, `h_req_ready` is 0 and the host request waits. The host request is accepted in the first cycle without an enclave request.
- R8: Configuration writes select a target with `cfg_sel`: 0 selects base, 1 selects mask, 2 selects lock. A lock write with `cfg_wdata` bit 0 = 1 sets `region_locked` from the next cycle. A lock write with bit 0 = 0 has no effect. While locked, writes to base and mask are ignored.
- R9: An `enc_unlock` pulse while locked clears `region_locked` and zeroes base and mask from the next cycle.
- R10: After reset the window is open with base and mask zero. `viol_flag`, `viol_count`, `h_rsp_valid` and `e_rsp_valid` are all 0, and `h_req_ready` is 1.
- R11: While the window is open, every host access reaches the bank and its response has `h_rsp_null` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 base, 1 mask, 2 lock |
| cfg_wdata | input | ADDR_W | Configuration write value; bit 0 is the lock request |
| enc_unlock | input | 1 | Enclave unlock pulse |
| h_req_valid | input | 1 | Host request present |
| h_req_ready | output | 1 | Host request accepted this cycle |
| h_req_write | input | 1 | Host request is a write |
| h_req_addr | input | ADDR_W | Host word address |
| h_req_wdata | input | DATA_W | Host write data |
| h_rsp_valid | output | 1 | Host response |
| h_rsp_null | output | 1 | Host access was blocked |
| h_rsp_rdata | output | DATA_W | Host read data, zero when blocked or for writes |
| e_req_valid | input | 1 | Enclave request present |
| e_req_write | input | 1 | Enclave request is a write |
| e_req_addr | input | ADDR_W | Enclave word address |
| e_req_wdata | input | DATA_W | Enclave write data |
| e_rsp_valid | output | 1 | Enclave response |
| e_rsp_rdata | output | DATA_W | Enclave read data |
| mem_en | output | 1 | Bank access enable |
| mem_we | output | 1 | Bank write enable |
| mem_addr | output | ADDR_W | Bank address |
| mem_wdata | output | DATA_W | Bank write data |
| mem_rdata | input | DATA_W | Bank read data, valid one cycle after the read |
| region_locked | output | 1 | Window is locked |
| viol_flag | output | 1 | Sticky blocked-write indicator |
| viol_count | output | CNT_W | Saturating blocked-write count |

## Verification
The bench builds the block with an 8-bit address, 16-bit data and a 3-bit violation counter. The narrow counter means nine blocked writes are enough to drive it past its ceiling of 7 and observe saturation. The 256-word address space lets the bench model the bank in full, so it can confirm that a dropped write left the stored word intact by reading it back through the enclave port. The bench also locks the window with a mask of zero after an unlock, which shows that the bounds were cleared because every address then becomes blocked.

// File: rtl/eg_pkg.sv
package eg_pkg;

    typedef enum logic [0:0] {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_t;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_LOCK = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_t;

endpackage

// File: rtl/eg_region_regs.sv
module eg_region_regs
    import eg_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              enc_unlock,
    output logic              locked,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] mask
);

    lock_state_t       state_q, state_d;
    logic [ADDR_W-1:0] base_q, mask_q;
    logic              lock_cmd;
    logic              unlock_go;
    logic              bounds_we;

    // A lock request is a write to the lock target with bit 0 set.
    always_comb begin
        lock_cmd = cfg_we && (cfg_sel_t'(cfg_sel) == SEL_LOCK) && cfg_wdata[0];
    end

    // Next-state logic: T_LOCK and T_UNLOCK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (lock_cmd)   state_d = ST_LOCKED;
            ST_LOCKED: if (enc_unlock) state_d = ST_OPEN;
            default:   state_d = ST_OPEN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // Output decode per state
    always_comb begin
        locked    = 1'b0;
        unlock_go = 1'b0;
        bounds_we = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                bounds_we = cfg_we;
            end
            ST_LOCKED: begin
                locked    = 1'b1;
                unlock_go = enc_unlock;
            end
            default: ;
        endcase
    end

    // Window bounds; frozen while locked, cleared on unlock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
        end else if (unlock_go) begin
            base_q <= '0;
            mask_q <= '0;
        end else if (bounds_we) begin
            if (cfg_sel_t'(cfg_sel) == SEL_BASE) base_q <= cfg_wdata;
            if (cfg_sel_t'(cfg_sel) == SEL_MASK) mask_q <= cfg_wdata;
        end
    end

    assign base = base_q;
    assign mask = mask_q;

endmodule

// File: rtl/eg_match.sv
module eg_match #(
    parameter int ADDR_W = 10
) (
    input  logic              locked,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    output logic              hit
);

    logic [ADDR_W-1:0] diff;

    // One XOR/AND per address bit, then a wide NOR.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign diff[i] = (addr[i] ^ base[i]) & mask[i];
    end

    assign hit = locked && (diff == '0);

endmodule

// File: rtl/eg_viol_track.sv
module eg_viol_track #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bad_write,
    output logic             flag,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             flag_q;
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            count_q <= '0;
        end else if (bad_write) begin
            flag_q <= 1'b1;
            if (count_q != CNT_MAX) count_q <= count_q + 1'b1;
        end
    end

    assign flag  = flag_q;
    assign count = count_q;

endmodule

// File: rtl/eg_port_mux.sv
module eg_port_mux #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_req_valid,
    input  logic              h_req_write,
    input  logic [ADDR_W-1:0] h_req_addr,
    input  logic [DATA_W-1:0] h_req_wdata,
    input  logic              h_hit,
    output logic              h_req_ready,
    output logic              h_acc,
    output logic              h_block,
    output logic              h_rsp_valid,
    output logic              h_rsp_null,
    output logic [DATA_W-1:0] h_rsp_rdata,
    input  logic              e_req_valid,
    input  logic              e_req_write,
    input  logic [ADDR_W-1:0] e_req_addr,
    input  logic [DATA_W-1:0] e_req_wdata,
    output logic              e_rsp_valid,
    output logic [DATA_W-1:0] e_rsp_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic h_pass;
    logic h_vld_q, h_null_q, h_rd_q;
    logic e_vld_q, e_rd_q;

    // Enclave owns the bank whenever it asks.
    assign h_req_ready = !e_req_valid;
    assign h_acc       = h_req_valid && h_req_ready;
    assign h_block     = h_acc && h_hit;
    assign h_pass      = h_acc && !h_hit;

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (e_req_valid) begin
            mem_en    = 1'b1;
            mem_we    = e_req_write;
            mem_addr  = e_req_addr;
            mem_wdata = e_req_wdata;
        end else if (h_pass) begin
            mem_en    = 1'b1;
            mem_we    = h_req_write;
            mem_addr  = h_req_addr;
            mem_wdata = h_req_wdata;
        end
    end

    // Fixed one-cycle response stage for both ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_vld_q  <= 1'b0;
            h_null_q <= 1'b0;
            h_rd_q   <= 1'b0;
            e_vld_q  <= 1'b0;
            e_rd_q   <= 1'b0;
        end else begin
            h_vld_q  <= h_acc;
            h_null_q <= h_block;
            h_rd_q   <= h_acc && !h_req_write;
            e_vld_q  <= e_req_valid;
            e_rd_q   <= e_req_valid && !e_req_write;
        end
    end

    assign h_rsp_valid = h_vld_q;
    assign h_rsp_null  = h_vld_q && h_null_q;
    assign h_rsp_rdata = (h_vld_q && h_rd_q && !h_null_q) ? mem_rdata : '0;
    assign e_rsp_valid = e_vld_q;
    assign e_rsp_rdata = (e_vld_q && e_rd_q) ? mem_rdata : '0;

endmodule

// File: rtl/enclave_guard.sv
module enclave_guard #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              enc_unlock,
    input  logic              h_req_valid,
    output logic              h_req_ready,
    input  logic              h_req_write,
    input  logic [ADDR_W-1:0] h_req_addr,
    input  logic [DATA_W-1:0] h_req_wdata,
    output logic              h_rsp_valid,
    output logic              h_rsp_null,
    output logic [DATA_W-1:0] h_rsp_rdata,
    input  logic              e_req_valid,
    input  logic              e_req_write,
    input  logic [ADDR_W-1:0] e_req_addr,
    input  logic [DATA_W-1:0] e_req_wdata,
    output logic              e_rsp_valid,
    output logic [DATA_W-1:0] e_rsp_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              region_locked,
    output logic              viol_flag,
    output logic [CNT_W-1:0]  viol_count
);

    logic              locked;
    logic [ADDR_W-1:0] base, mask;
    logic              h_hit;
    logic              h_acc;
    logic              h_block;
    logic              bad_write;

    eg_region_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .enc_unlock (enc_unlock),
        .locked     (locked),
        .base       (base),
        .mask       (mask)
    );

    eg_match #(.ADDR_W(ADDR_W)) u_match (
        .locked (locked),
        .addr   (h_req_addr),
        .base   (base),
        .mask   (mask),
        .hit    (h_hit)
    );

    eg_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .h_req_valid (h_req_valid),
        .h_req_write (h_req_write),
        .h_req_addr  (h_req_addr),
        .h_req_wdata (h_req_wdata),
        .h_hit       (h_hit),
        .h_req_ready (h_req_ready),
        .h_acc       (h_acc),
        .h_block     (h_block),
        .h_rsp_valid (h_rsp_valid),
        .h_rsp_null  (h_rsp_null),
        .h_rsp_rdata (h_rsp_rdata),
        .e_req_valid (e_req_valid),
        .e_req_write (e_req_write),
        .e_req_addr  (e_req_addr),
        .e_req_wdata (e_req_wdata),
        .e_rsp_valid (e_rsp_valid),
        .e_rsp_rdata (e_rsp_rdata),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata)
    );

    assign bad_write = h_block && h_req_write;

    eg_viol_track #(.CNT_W(CNT_W)) u_viol (
        .clk       (clk),
        .rst_n     (rst_n),
        .bad_write (bad_write),
        .flag      (viol_flag),
        .count     (viol_count)
    );

    assign region_locked = locked;

endmodule

// File: rtl/eg_checker.sv
module eg_checker #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_acc,
    input logic              h_block,
    input logic              h_req_write,
    input logic              h_req_ready,
    input logic              h_rsp_valid,
    input logic              h_rsp_null,
    input logic [DATA_W-1:0] h_rsp_rdata,
    input logic              e_req_valid,
    input logic              mem_en,
    input logic              locked,
    input logic [ADDR_W-1:0] base,
    input logic [ADDR_W-1:0] mask,
    input logic              enc_unlock,
    input logic              viol_flag,
    input logic [CNT_W-1:0]  viol_count
);

    assert_null_no_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        h_rsp_valid && h_rsp_null |-> h_rsp_rdata == '0);

    assert_blocked_no_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        h_block |-> !mem_en);

    assert_blocked_write_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        h_block && h_req_write |=> viol_flag);

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |=> viol_flag);

    assert_count_no_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        h_acc || !h_acc |=> viol_count >= $past(viol_count));

    assert_rsp_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        h_acc |=> h_rsp_valid);

    assert_no_spurious_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !h_acc |=> !h_rsp_valid);

    assert_enclave_reaches_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        e_req_valid |-> mem_en);

    assert_enclave_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        e_req_valid |-> !h_req_ready);

    assert_bounds_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        locked && !enc_unlock |=> $stable(base) && $stable(mask) && locked);

    assert_unlock_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        locked && enc_unlock |=> !locked && base == '0 && mask == '0);

    assert_open_never_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !h_block);

endmodule

bind enclave_guard eg_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .h_acc       (h_acc),
    .h_block     (h_block),
    .h_req_write (h_req_write),
    .h_req_ready (h_req_ready),
    .h_rsp_valid (h_rsp_valid),
    .h_rsp_null  (h_rsp_null),
    .h_rsp_rdata (h_rsp_rdata),
    .e_req_valid (e_req_valid),
    .mem_en      (mem_en),
    .locked      (locked),
    .base        (base),
    .mask        (mask),
    .enc_unlock  (enc_unlock),
    .viol_flag   (viol_flag),
    .viol_count  (viol_count)
);

// File: tb/enclave_guard_test.sv
module enclave_guard_test;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd3;
    logic [AW-1:0] cfg_wdata = '0;
    logic          enc_unlock = 1'b0;
    logic          h_req_valid = 1'b0;
    logic          h_req_ready;
    logic          h_req_write = 1'b0;
    logic [AW-1:0] h_req_addr = '0;
    logic [DW-1:0] h_req_wdata = '0;
    logic          h_rsp_valid, h_rsp_null;
    logic [DW-1:0] h_rsp_rdata;
    logic          e_req_valid = 1'b0;
    logic          e_req_write = 1'b0;
    logic [AW-1:0] e_req_addr = '0;
    logic [DW-1:0] e_req_wdata = '0;
    logic          e_rsp_valid;
    logic [DW-1:0] e_rsp_rdata;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          region_locked, viol_flag;
    logic [CW-1:0] viol_count;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [DW-1:0] bank [256];

    always #5 clk = ~clk;

    // Bank model: registered read, one-cycle latency.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) bank[mem_addr] <= mem_wdata;
            mem_rdata <= bank[mem_addr];
        end
    end

    enclave_guard #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .enc_unlock(enc_unlock),
        .h_req_valid(h_req_valid), .h_req_ready(h_req_ready),
        .h_req_write(h_req_write), .h_req_addr(h_req_addr), .h_req_wdata(h_req_wdata),
        .h_rsp_valid(h_rsp_valid), .h_rsp_null(h_rsp_null), .h_rsp_rdata(h_rsp_rdata),
        .e_req_valid(e_req_valid), .e_req_write(e_req_write),
        .e_req_addr(e_req_addr), .e_req_wdata(e_req_wdata),
        .e_rsp_valid(e_rsp_valid), .e_rsp_rdata(e_rsp_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .region_locked(region_locked), .viol_flag(viol_flag), .viol_count(viol_count)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 2'd3;
    endtask

    task automatic unlock_pulse();
        enc_unlock = 1'b1;
        @(posedge clk); @(negedge clk);
        enc_unlock = 1'b0;
    endtask

    task automatic host_acc(input string tag, input logic w, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input logic exp_null,
                            input logic [DW-1:0] exp_data);
        h_req_valid = 1'b1; h_req_write = w; h_req_addr = a; h_req_wdata = d;
        #1 check({tag, " R7 ready"}, h_req_ready, 1'b1);
        @(posedge clk); @(negedge clk);
        h_req_valid = 1'b0; h_req_write = 1'b0;
        check({tag, " R5 valid"}, h_rsp_valid, 1'b1);
        check({tag, " null"}, h_rsp_null, exp_null);
        check({tag, " data"}, h_rsp_rdata, exp_data);
        @(posedge clk); @(negedge clk);
        check({tag, " R5 single pulse"}, h_rsp_valid, 1'b0);
    endtask

    task automatic enc_acc(input string tag, input logic w, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic [DW-1:0] exp_data);
        e_req_valid = 1'b1; e_req_write = w; e_req_addr = a; e_req_wdata = d;
        @(posedge clk); @(negedge clk);
        e_req_valid = 1'b0; e_req_write = 1'b0;
        check({tag, " R6 valid"}, e_rsp_valid, 1'b1);
        check({tag, " R6 data"}, e_rsp_rdata, exp_data);
    endtask

    task automatic t_reset();
        check("R10 locked", region_locked, 1'b0);
        check("R10 flag", viol_flag, 1'b0);
        check("R10 count", viol_count, 0);
        check("R10 h_rsp", h_rsp_valid, 1'b0);
        check("R10 e_rsp", e_rsp_valid, 1'b0);
        check("R10 ready", h_req_ready, 1'b1);
    endtask

    task automatic t_open();
        host_acc("R11 write 45", 1'b1, 8'h45, 16'h1234, 1'b0, 16'h0);
        host_acc("R11 write 4f", 1'b1, 8'h4F, 16'h4F4F, 1'b0, 16'h0);
        host_acc("R11 write 85", 1'b1, 8'h85, 16'h8585, 1'b0, 16'h0);
        host_acc("R11 write 05", 1'b1, 8'h05, 16'h0505, 1'b0, 16'h0);
        host_acc("R11 write c3", 1'b1, 8'hC3, 16'hC3C3, 1'b0, 16'h0);
        cfg_write(2'd0, 8'h40);
        cfg_write(2'd1, 8'hF0);
        host_acc("R11 open read in window", 1'b0, 8'h45, 16'h0, 1'b0, 16'h1234);
        cfg_write(2'd2, 8'h00);
        check("R8 lock bit0=0 ignored", region_locked, 1'b0);
    endtask

    task automatic t_locked_read();
        cfg_write(2'd2, 8'h01);
        check("R8 lock set", region_locked, 1'b1);
        host_acc("R2 blocked read 45", 1'b0, 8'h45, 16'h0, 1'b1, 16'h0);
        host_acc("R1 blocked read 4f", 1'b0, 8'h4F, 16'h0, 1'b1, 16'h0);
        host_acc("R1 miss read 85", 1'b0, 8'h85, 16'h0, 1'b0, 16'h8585);
        check("R4 reads not counted", viol_count, 0);
        check("R4 reads no flag", viol_flag, 1'b0);
    endtask

    task automatic t_locked_write();
        host_acc("R3 blocked write 45", 1'b1, 8'h45, 16'hDEAD, 1'b1, 16'h0);
        check("R4 flag", viol_flag, 1'b1);
        check("R4 count", viol_count, 1);
        enc_acc("R3 bank intact", 1'b0, 8'h45, 16'h0, 16'h1234);
        enc_acc("R6 enclave write", 1'b1, 8'h4F, 16'hBEEF, 16'h0);
        enc_acc("R6 enclave read", 1'b0, 8'h4F, 16'h0, 16'hBEEF);
    endtask

    task automatic t_frozen();
        cfg_write(2'd0, 8'h80);
        cfg_write(2'd1, 8'h00);
        host_acc("R8 base frozen 45", 1'b0, 8'h45, 16'h0, 1'b1, 16'h0);
        host_acc("R8 base frozen 85", 1'b0, 8'h85, 16'h0, 1'b0, 16'h8585);
    endtask

    task automatic t_priority();
        e_req_valid = 1'b1; e_req_write = 1'b0; e_req_addr = 8'h85;
        h_req_valid = 1'b1; h_req_write = 1'b0; h_req_addr = 8'h05;
        #1 check("R7 host held", h_req_ready, 1'b0);
        @(posedge clk); @(negedge clk);
        e_req_valid = 1'b0;
        check("R7 enclave served", e_rsp_valid, 1'b1);
        check("R7 enclave data", e_rsp_rdata, 16'h8585);
        check("R7 host not yet", h_rsp_valid, 1'b0);
        @(posedge clk); @(negedge clk);
        h_req_valid = 1'b0;
        check("R7 host served", h_rsp_valid, 1'b1);
        check("R7 host data", h_rsp_rdata, 16'h0505);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 8; i++) begin
            host_acc("R4 sat write", 1'b1, 8'h40, 16'hFFFF, 1'b1, 16'h0);
        end
        check("R4 saturated", viol_count, 7);
    endtask

    task automatic t_unlock();
        unlock_pulse();
        check("R9 unlocked", region_locked, 1'b0);
        check("R4 flag across unlock", viol_flag, 1'b1);
        host_acc("R9 open after unlock", 1'b0, 8'h45, 16'h0, 1'b0, 16'h1234);
        // Only mask written: base must now be zero.
        cfg_write(2'd1, 8'hF0);
        cfg_write(2'd2, 8'h01);
        host_acc("R9 base cleared hit 05", 1'b0, 8'h05, 16'h0, 1'b1, 16'h0);
        host_acc("R9 base cleared miss 45", 1'b0, 8'h45, 16'h0, 1'b0, 16'h1234);
        unlock_pulse();
        // Nothing written: mask zero covers all addresses.
        cfg_write(2'd2, 8'h01);
        host_acc("R1 zero mask c3", 1'b0, 8'hC3, 16'h0, 1'b1, 16'h0);
        host_acc("R1 zero mask 85", 1'b0, 8'h85, 16'h0, 1'b1, 16'h0);
        unlock_pulse();
        check("R9 unlocked again", region_locked, 1'b0);
        check("R4 count held", viol_count, 7);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_open();
        t_locked_read();
        t_locked_write();
        t_frozen();
        t_priority();
        t_saturate();
        t_unlock();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule